// File: doc/BRIEF.md
# Multi-Operand Carry-Save Summation Tree

This block adds a parameterised number of operands into one result word of `SUM_W` bits. The result wraps modulo 2^SUM_W. It is purely combinational: there is no clock and no reset. Each operand has its own width and its own signed/unsigned flag, both fixed at elaboration. The operands are packed back to back into one input bus, with operand 0 in the least significant bits.

Every operand is first aligned to `SUM_W` bits. The aligned words then pass through levels of word-wide 3:2 compressors. At each level the live words are taken in order, three at a time. Each triple becomes a sum word and a carry word. The carry word is moved up one bit, with a zero entering bit 0 and its top bit dropped. One or two words left over at the end of a level go on to the next level unchanged. When two words remain, a single ripple carry-propagate adder produces the output. With two operands, only that adder is used. With one operand, the aligned operand itself is the output.

Top module: `csaTreeSum`

## Requirements
- R1: An unsigned operand narrower than `SUM_W` is zero-filled above its top bit before it is summed.
- R2: A signed operand narrower than `SUM_W` has its top bit copied into every higher position up to `SUM_W`.
- R3: An operand wider than `SUM_W` contributes only its low `SUM_W` bits.
- R4: For three or more operands, `sumOut` equals the sum of all aligned operands, modulo 2^SUM_W, for arbitrary operand values.
- R5: A total that overflows `SUM_W` bits wraps (for example, all operands set to all ones), and the final carry-propagate adder returns its two inputs' sum modulo 2^SUM_W.
- R6: The result is correct whether or not the operand count is a multiple of three (checked with 3, 5 and 7 operands).
- R7: With exactly two operands the block is a plain `SUM_W`-bit adder of the two aligned operands; with one operand, `sumOut` is the aligned operand.
- R8: `sumOut` follows its inputs with no clock edge in between, and all-zero inputs give a zero result.
- R9: Each compressor produces a sum word and a carry word whose modular sum equals the modular sum of its three input words. The carry word has bit 0 at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opsIn | input | IN_TOTAL (sum of the per-operand widths, 77 by default) | All operands packed back to back, operand 0 at bit 0, each at its own width |
| sumOut | output | SUM_W | Sum of the aligned operands modulo 2^SUM_W |

## Verification
Every result of this block is due in the same cycle as its stimulus: the path from `opsIn` to `sumOut` contains no register. The bench changes the operand buses on a rising clock edge and reads every `sumOut` at the falling edge that follows, half a period later, when the combinational tree has settled. It checks five instances at once with one, two, three, five and seven operands. These instances mix narrow, wide, signed and unsigned operands, so each stimulus covers the alignment rules, the leftover handling at each level and the two degenerate cases.

// File: rtl/csaTreePkg.sv
package csaTreePkg;

  localparam int MAX_OPS = 16;

  // packed per-operand widths, 8 bits per field, operand 0 lowest
  typedef logic [MAX_OPS*8-1:0] widthVecT;

  function automatic int fieldWidth(input widthVecT v, input int idx);
    return int'(v[idx*8 +: 8]);
  endfunction

  function automatic int bitOffset(input widthVecT v, input int idx);
    int acc;
    acc = 0;
    for (int k = 0; k < idx; k++) acc += int'(v[k*8 +: 8]);
    return acc;
  endfunction

  // word count after one level of in-order triplet compression
  function automatic int nextCount(input int n);
    return 2 * (n / 3) + (n % 3);
  endfunction

  function automatic int levelCount(input int n);
    int cnt, lvls;
    cnt = n;
    lvls = 0;
    while (cnt > 2) begin
      cnt = nextCount(cnt);
      lvls++;
    end
    return lvls;
  endfunction

  function automatic int countAt(input int n, input int lvl);
    int cnt;
    cnt = n;
    for (int k = 0; k < lvl; k++) cnt = nextCount(cnt);
    return cnt;
  endfunction

  // slot index where a given level's words start in the flat chain bus
  function automatic int slotOffset(input int n, input int lvl);
    int acc;
    acc = 0;
    for (int k = 0; k < lvl; k++) acc += countAt(n, k);
    return acc;
  endfunction

  function automatic int slotTotal(input int n);
    return slotOffset(n, levelCount(n) + 1);
  endfunction

endpackage

// File: rtl/csaOperandAlign.sv
module csaOperandAlign #(
  parameter int IN_W = 8,
  parameter int W = 16,
  parameter bit IS_SIGNED = 1'b0
) (
  input  logic [IN_W-1:0] rawW,
  output logic [W-1:0]    alignedW
);

  generate
    if (IN_W >= W) begin : gTrunc
      always_comb begin
        alignedW = rawW[W-1:0];
        // R3
        align_trunc_chk: assert (((rawW >> W) << W) == (rawW - IN_W'(alignedW)));
      end
    end else if (IS_SIGNED) begin : gSext
      always_comb begin
        alignedW = {{(W-IN_W){rawW[IN_W-1]}}, rawW};
        // R2
        align_sign_chk: assert ($signed(alignedW) == $signed(rawW));
      end
    end else begin : gZext
      always_comb begin
        alignedW = {{(W-IN_W){1'b0}}, rawW};
        // R1
        align_zero_chk: assert (({1'b0, alignedW} < ((W+1)'(1) << IN_W))
                                && (alignedW[IN_W-1:0] == rawW));
      end
    end
  endgenerate

endmodule

// File: rtl/csaCompress.sv
module csaCompress #(
  parameter int W = 16
) (
  input  logic [W-1:0] aW,
  input  logic [W-1:0] bW,
  input  logic [W-1:0] cW,
  output logic [W-1:0] sumW,
  output logic [W-1:0] carryW
);

  always_comb begin
    sumW = aW ^ bW ^ cW;
    carryW = '0;
    for (int i = 0; i < W - 1; i++) begin
      carryW[i+1] = (aW[i] & bW[i]) | (aW[i] & cW[i]) | (bW[i] & cW[i]);
    end
    // R9
    compress_keep_chk: assert (W'(sumW + carryW) == W'(aW + bW + cW));
  end

endmodule

// File: rtl/csaLevel.sv
module csaLevel #(
  parameter int W = 16,
  parameter int IN_CNT = 3,
  localparam int GROUPS = IN_CNT / 3,
  localparam int REM = IN_CNT % 3,
  localparam int OUT_CNT = 2 * GROUPS + REM
) (
  input  logic [IN_CNT*W-1:0]  inBus,
  output logic [OUT_CNT*W-1:0] outBus
);

  generate
    for (genvar g = 0; g < GROUPS; g++) begin : gTriple
      csaCompress #(.W(W)) uComp (
        .aW    (inBus[(3*g)*W   +: W]),
        .bW    (inBus[(3*g+1)*W +: W]),
        .cW    (inBus[(3*g+2)*W +: W]),
        .sumW  (outBus[(2*g)*W   +: W]),
        .carryW(outBus[(2*g+1)*W +: W])
      );
    end
    for (genvar r = 0; r < REM; r++) begin : gPass
      assign outBus[(2*GROUPS+r)*W +: W] = inBus[(3*GROUPS+r)*W +: W];
    end
  endgenerate

endmodule

// File: rtl/cpaRipple.sv
module cpaRipple #(
  parameter int W = 16
) (
  input  logic [W-1:0] xW,
  input  logic [W-1:0] yW,
  output logic [W-1:0] sumOut
);

  logic cy;

  always_comb begin
    cy = 1'b0;
    sumOut = '0;
    for (int i = 0; i < W; i++) begin
      sumOut[i] = xW[i] ^ yW[i] ^ cy;
      cy = (xW[i] & yW[i]) | (cy & (xW[i] ^ yW[i]));
    end
    // R5
    ripple_mod_chk: assert (sumOut == W'(xW + yW));
  end

endmodule

// File: rtl/csaTreeSum.sv
module csaTreeSum import csaTreePkg::*; #(
  parameter int NUM_OPS = 7,
  parameter int SUM_W = 16,
  parameter logic [NUM_OPS*8-1:0] OP_WIDTHS = {8'd1, 8'd12, 8'd20, 8'd4, 8'd16, 8'd16, 8'd8},
  parameter logic [NUM_OPS-1:0] OP_SIGNED = 7'b0101011,
  localparam widthVecT WV = widthVecT'(OP_WIDTHS),
  localparam int IN_TOTAL = bitOffset(WV, NUM_OPS),
  localparam int LEVELS = levelCount(NUM_OPS),
  localparam int SLOTS = slotTotal(NUM_OPS),
  localparam int LAST_SLOT = slotOffset(NUM_OPS, LEVELS)
) (
  input  logic [IN_TOTAL-1:0] opsIn,
  output logic [SUM_W-1:0]    sumOut
);

  // every word of every level, level 0 first
  logic [SLOTS*SUM_W-1:0] chainW;

  generate
    for (genvar i = 0; i < NUM_OPS; i++) begin : gAlign
      localparam int OFF = bitOffset(WV, i);
      localparam int OW = fieldWidth(WV, i);
      csaOperandAlign #(.IN_W(OW), .W(SUM_W), .IS_SIGNED(OP_SIGNED[i])) uAlign (
        .rawW    (opsIn[OFF +: OW]),
        .alignedW(chainW[i*SUM_W +: SUM_W])
      );
    end

    for (genvar l = 0; l < LEVELS; l++) begin : gLevel
      localparam int SRC = slotOffset(NUM_OPS, l);
      localparam int DST = slotOffset(NUM_OPS, l + 1);
      localparam int CNT_IN = countAt(NUM_OPS, l);
      localparam int CNT_OUT = countAt(NUM_OPS, l + 1);
      csaLevel #(.W(SUM_W), .IN_CNT(CNT_IN)) uLevel (
        .inBus (chainW[SRC*SUM_W +: CNT_IN*SUM_W]),
        .outBus(chainW[DST*SUM_W +: CNT_OUT*SUM_W])
      );
    end

    if (NUM_OPS == 1) begin : gSingle
      assign sumOut = chainW[SUM_W-1:0];
    end else begin : gFinal
      cpaRipple #(.W(SUM_W)) uCpa (
        .xW    (chainW[LAST_SLOT*SUM_W +: SUM_W]),
        .yW    (chainW[(LAST_SLOT+1)*SUM_W +: SUM_W]),
        .sumOut(sumOut)
      );
    end
  endgenerate

  logic [SUM_W-1:0] alignedTotal;

  always_comb begin
    alignedTotal = '0;
    for (int i = 0; i < NUM_OPS; i++) alignedTotal += chainW[i*SUM_W +: SUM_W];
    // R4
    tree_total_chk: assert (sumOut == alignedTotal);
  end

endmodule

// File: tb/sim_csaTreeSum.sv
`timescale 1ns/1ps
module sim_csaTreeSum;

  localparam logic [55:0] WV0 = {8'd1, 8'd12, 8'd20, 8'd4, 8'd16, 8'd16, 8'd8};
  localparam logic [6:0]  SG0 = 7'b0101011;
  localparam logic [23:0] WV1 = {8'd16, 8'd8, 8'd24};
  localparam logic [2:0]  SG1 = 3'b010;
  localparam logic [39:0] WV2 = {8'd32, 8'd6, 8'd24, 8'd10, 8'd24};
  localparam logic [4:0]  SG2 = 5'b01010;
  localparam logic [15:0] WV3 = {8'd7, 8'd12};
  localparam logic [1:0]  SG3 = 2'b10;
  localparam logic [7:0]  WV4 = 8'd6;
  localparam logic [0:0]  SG4 = 1'b1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic [76:0] in0;
  logic [47:0] in1;
  logic [95:0] in2;
  logic [18:0] in3;
  logic [5:0]  in4;
  logic [15:0] out0;
  logic [15:0] out1;
  logic [23:0] out2;
  logic [11:0] out3;
  logic [9:0]  out4;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  csaTreeSum #(.NUM_OPS(7), .SUM_W(16), .OP_WIDTHS(WV0), .OP_SIGNED(SG0)) u0 (.opsIn(in0), .sumOut(out0));
  csaTreeSum #(.NUM_OPS(3), .SUM_W(16), .OP_WIDTHS(WV1), .OP_SIGNED(SG1)) u1 (.opsIn(in1), .sumOut(out1));
  csaTreeSum #(.NUM_OPS(5), .SUM_W(24), .OP_WIDTHS(WV2), .OP_SIGNED(SG2)) u2 (.opsIn(in2), .sumOut(out2));
  csaTreeSum #(.NUM_OPS(2), .SUM_W(12), .OP_WIDTHS(WV3), .OP_SIGNED(SG3)) u3 (.opsIn(in3), .sumOut(out3));
  csaTreeSum #(.NUM_OPS(1), .SUM_W(10), .OP_WIDTHS(WV4), .OP_SIGNED(SG4)) u4 (.opsIn(in4), .sumOut(out4));

  // expected sum: extend each operand to 64 bits per its flag, add, keep w bits
  function automatic logic [63:0] refSum(input logic [127:0] ops, input int n,
                                         input logic [127:0] widths, input logic [15:0] sgn,
                                         input int w);
    logic [63:0] acc, v;
    int off, wi;
    acc = '0;
    off = 0;
    for (int i = 0; i < n; i++) begin
      wi = int'(widths[i*8 +: 8]);
      v = '0;
      for (int b = 0; b < wi; b++) v[b] = ops[off+b];
      if (sgn[i] && v[wi-1]) for (int b = wi; b < 64; b++) v[b] = 1'b1;
      acc += v;
      off += wi;
    end
    return acc & ((64'd1 << w) - 64'd1);
  endfunction

  // directed patterns: 0 zeros, 1 all ones, 2 most negative signed,
  // 3 unsigned all ones with signed zero, 4 wide operands with bits above w
  function automatic logic [127:0] pattern(input int mode, input int n,
                                           input logic [127:0] widths, input logic [15:0] sgn,
                                           input int w);
    logic [127:0] r;
    int off, wi;
    r = '0;
    off = 0;
    for (int i = 0; i < n; i++) begin
      wi = int'(widths[i*8 +: 8]);
      for (int b = 0; b < wi; b++) begin
        case (mode)
          1: r[off+b] = 1'b1;
          2: r[off+b] = sgn[i] && (b == wi - 1);
          3: r[off+b] = !sgn[i];
          4: r[off+b] = (wi > w) && (b >= w || b == 0);
          default: r[off+b] = 1'b0;
        endcase
      end
      off += wi;
    end
    return r;
  endfunction

  task automatic checkOne(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    @(negedge clk);
    checkOne({tag, " R6 n7"}, 64'(out0), refSum(128'(in0), 7, 128'(WV0), 16'(SG0), 16));
    checkOne({tag, " R6 n3"}, 64'(out1), refSum(128'(in1), 3, 128'(WV1), 16'(SG1), 16));
    checkOne({tag, " R6 n5"}, 64'(out2), refSum(128'(in2), 5, 128'(WV2), 16'(SG2), 24));
    checkOne({tag, " R7 n2"}, 64'(out3), refSum(128'(in3), 2, 128'(WV3), 16'(SG3), 12));
    checkOne({tag, " R7 n1"}, 64'(out4), refSum(128'(in4), 1, 128'(WV4), 16'(SG4), 10));
  endtask

  task automatic applyPattern(input int mode);
    @(posedge clk);
    in0 = 77'(pattern(mode, 7, 128'(WV0), 16'(SG0), 16));
    in1 = 48'(pattern(mode, 3, 128'(WV1), 16'(SG1), 16));
    in2 = 96'(pattern(mode, 5, 128'(WV2), 16'(SG2), 24));
    in3 = 19'(pattern(mode, 2, 128'(WV3), 16'(SG3), 12));
    in4 = 6'(pattern(mode, 1, 128'(WV4), 16'(SG4), 10));
  endtask

  initial begin
    logic [95:0] rnd;
    void'($urandom(32'd20240611));
    in0 = '0; in1 = '0; in2 = '0; in3 = '0; in4 = '0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;

    // R8: zero inputs give zero, settled within the same cycle
    @(negedge clk);
    checkOne("R8 zero n7", 64'(out0), 64'd0);
    checkOne("R8 zero n3", 64'(out1), 64'd0);
    checkOne("R8 zero n5", 64'(out2), 64'd0);
    checkOne("R8 zero n2", 64'(out3), 64'd0);
    checkOne("R8 zero n1", 64'(out4), 64'd0);

    applyPattern(1); checkAll("R5 all-ones wrap");
    applyPattern(2); checkAll("R2 most-negative");
    applyPattern(3); checkAll("R1 unsigned ones");
    applyPattern(4); checkAll("R3 wide truncate");
    applyPattern(0); checkAll("R8 back to zero");

    // R4 R9 random operands, mixed with a few all-ones words
    for (int t = 0; t < 400; t++) begin
      @(posedge clk);
      rnd = {$urandom(), $urandom(), $urandom()};
      if (t % 17 == 0) rnd = ~96'd0 ^ (96'd1 << (t % 96));
      in0 = rnd[76:0];
      in1 = rnd[95:48];
      rnd = {$urandom(), $urandom(), $urandom()};
      in2 = rnd;
      in3 = rnd[50:32];
      in4 = rnd[5:0];
      checkAll("R4 R9 random");
    end

    done = 1'b1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule